// File: doc/BRIEF.md
# Multicycle 16-bit Register-File Microcontroller Core

This block is a compact multicycle processor made of a controller state machine and a datapath. The datapath holds a 16-bit program counter, a 16-bit instruction register, sixteen 16-bit general registers and one arithmetic unit. Code and data share one word-addressed memory inside the block. After reset the core repeats the same sequence: it fetches a word, decodes it in a separate cycle, and runs one execute state. The instruction set has seven operations: load from a direct address, store to a direct address, store through a register pointer, load immediate, add, subtract, and branch when a register is zero.

Instruction fields: opcode = bits 15:12, first register `rn` = bits 11:8, second register `rm` = bits 7:4, and an 8-bit literal = bits 7:0. The literal serves as a direct address, an immediate or a branch target, and is always zero-extended. A debug port writes memory while reset is held, and it can read memory, the register file, the PC and the controller state at any time. A test environment uses it to load programs and to compare the core against a model.

Top module: `mcu16_core`

## Requirements
- R1: While `rst` is high on a rising edge, the PC becomes 0, the state becomes fetch (code 0), and all sixteen registers become 0.
- R2: Fetch (state 0) loads the IR from memory at the PC and increments the PC. The next state is decode (code 1). Execute states use code opcode+2 (2 to 8).
- R3: Field layout: opcode = IR[15:12], rn = IR[11:8], rm = IR[7:4], literal = IR[7:0]. Word format `{op, rn, rm/lit_hi, lit_lo}`.
- R4: Opcode 0000 writes memory[literal] into register rn.
- R5: Opcode 0001 writes register rn to memory[literal].
- R6: Opcode 0010 writes register rm to memory at the address held in register rn.
- R7: Opcode 0011 writes the zero-extended literal into register rn.
- R8: Opcode 0100 writes rn+rm into rn. Opcode 0101 writes rn-rm into rn. Both wrap modulo 2^16.
- R9: Opcode 0110 sets the PC to the zero-extended literal when register rn is 0. Otherwise the PC does not change.
- R10: Opcodes 0111 to 1111 change no register and no memory word. Decode then goes straight back to fetch, so such an instruction takes two cycles.
- R11: Every execute state lasts one cycle and is followed by fetch. Its register or memory write lands on the edge that ends it. Only opcodes 0001 and 0010 write memory.
- R12: Memory addresses are taken modulo MEM_DEPTH. A debug write lands only on an edge where `rst` is high and is ignored otherwise. Debug reads of memory and registers are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dbg_mem_we | input | 1 | Debug memory write strobe (used only while rst is high) |
| dbg_mem_addr | input | 16 | Debug memory word address, for both write and read |
| dbg_mem_wdata | input | 16 | Debug memory write data |
| dbg_mem_rdata | output | 16 | Memory word at dbg_mem_addr |
| dbg_rf_sel | input | 4 | Register index for debug read |
| dbg_rf_data | output | 16 | Contents of the selected register |
| dbg_pc | output | 16 | Current program counter |
| dbg_state | output | 4 | Controller state code |

## Verification
Each instruction takes three cycles and each undefined opcode takes two. Every result is due on the edge that ends the state which produces it: the PC and IR one edge after fetch, register and memory writes and branch targets one edge after the execute state. The bench holds a behavioural model that advances at every rising edge. Half a cycle later, away from the edge, it compares the PC, the state code and one register chosen in rotation. Memory contents and the specific results each opcode should produce are checked once the program has settled into its final self-loop.

// File: rtl/mcu16_pkg.sv
package mcu16_pkg;

   localparam int WORD_W = 16;
   localparam int OP_W   = 4;
   localparam int REG_AW = 4;
   localparam int LIT_W  = 8;

   typedef enum logic [3:0] {
      ST_FETCH  = 4'd0,
      ST_DECODE = 4'd1,
      ST_LDD    = 4'd2,
      ST_STD    = 4'd3,
      ST_STI    = 4'd4,
      ST_LDI    = 4'd5,
      ST_ADD    = 4'd6,
      ST_SUB    = 4'd7,
      ST_JZ     = 4'd8
   } state_t;

   typedef enum logic [1:0] {
      WSRC_ALU = 2'b00,
      WSRC_MEM = 2'b01,
      WSRC_IMM = 2'b10
   } wsrc_t;

   typedef enum logic [1:0] {
      ASEL_PC  = 2'b00,
      ASEL_LIT = 2'b01,
      ASEL_RD1 = 2'b10
   } asel_t;

   typedef enum logic [1:0] {
      ALU_ADD  = 2'b00,
      ALU_SUB  = 2'b01,
      ALU_PASS = 2'b10
   } aluop_t;

   typedef struct packed {
      logic   rf_we;
      wsrc_t  wsrc;
      asel_t  asel;
      logic   mem_we;
      logic   wd_rm;
      aluop_t alu;
      logic   ir_ld;
      logic   pc_inc;
      logic   pc_ld_z;
   } ctrl_t;

   localparam logic [OP_W-1:0] LAST_DEFINED_OP = 4'd6;

endpackage

// File: rtl/mcu16_ctrl.sv
module mcu16_ctrl
   import mcu16_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] opcode,
   output state_t          state,
   output ctrl_t           ctl
);

   state_t state_q;
   state_t state_d;

   always_ff @(posedge clk) begin
      if (rst) state_q <= ST_FETCH;
      else     state_q <= state_d;
   end

   always_comb begin
      state_d = ST_FETCH;
      unique case (state_q)
         ST_FETCH:  state_d = ST_DECODE;
         ST_DECODE: begin
            if (opcode <= LAST_DEFINED_OP) state_d = state_t'(opcode + 4'd2);
            else                           state_d = ST_FETCH;
         end
         default:   state_d = ST_FETCH;
      endcase
   end

   always_comb begin
      ctl.rf_we   = 1'b0;
      ctl.wsrc    = WSRC_ALU;
      ctl.asel    = ASEL_PC;
      ctl.mem_we  = 1'b0;
      ctl.wd_rm   = 1'b0;
      ctl.alu     = ALU_ADD;
      ctl.ir_ld   = 1'b0;
      ctl.pc_inc  = 1'b0;
      ctl.pc_ld_z = 1'b0;
      unique case (state_q)
         ST_FETCH: begin
            ctl.asel   = ASEL_PC;
            ctl.ir_ld  = 1'b1;
            ctl.pc_inc = 1'b1;
         end
         ST_LDD: begin
            ctl.asel  = ASEL_LIT;
            ctl.wsrc  = WSRC_MEM;
            ctl.rf_we = 1'b1;
         end
         ST_STD: begin
            ctl.asel   = ASEL_LIT;
            ctl.mem_we = 1'b1;
         end
         ST_STI: begin
            ctl.asel   = ASEL_RD1;
            ctl.wd_rm  = 1'b1;
            ctl.mem_we = 1'b1;
         end
         ST_LDI: begin
            ctl.wsrc  = WSRC_IMM;
            ctl.rf_we = 1'b1;
         end
         ST_ADD: begin
            ctl.alu   = ALU_ADD;
            ctl.wsrc  = WSRC_ALU;
            ctl.rf_we = 1'b1;
         end
         ST_SUB: begin
            ctl.alu   = ALU_SUB;
            ctl.wsrc  = WSRC_ALU;
            ctl.rf_we = 1'b1;
         end
         ST_JZ: begin
            ctl.alu     = ALU_PASS;
            ctl.pc_ld_z = 1'b1;
         end
         default: ;
      endcase
   end

   assign state = state_q;

endmodule

// File: rtl/mcu16_alu.sv
module mcu16_alu
   import mcu16_pkg::*;
#(
   parameter int W            = 16,
   parameter bit SHARED_ADDER = 1'b1
)(
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  aluop_t       op,
   output logic [W-1:0] y,
   output logic         z
);

   logic [W-1:0] arith;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic         is_sub;
         logic [W-1:0] b_eff;
         assign is_sub = (op == ALU_SUB);
         assign b_eff  = is_sub ? ~b : b;
         assign arith  = a + b_eff + {{(W-1){1'b0}}, is_sub};
      end else begin : g_split
         logic [W-1:0] sum;
         logic [W-1:0] dif;
         assign sum   = a + b;
         assign dif   = a - b;
         assign arith = (op == ALU_SUB) ? dif : sum;
      end
   endgenerate

   always_comb begin
      if (op == ALU_PASS) y = a;
      else                y = arith;
   end

   assign z = (y == '0);

endmodule

// File: rtl/mcu16_regfile.sv
module mcu16_regfile #(
   parameter int W     = 16,
   parameter int N     = 16,
   localparam int AW   = $clog2(N)
)(
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr1,
   output logic [W-1:0]  rdata1,
   input  logic [AW-1:0] raddr2,
   output logic [W-1:0]  rdata2,
   input  logic [AW-1:0] raddr3,
   output logic [W-1:0]  rdata3
);

   logic [W-1:0] rows [N];

   generate
      for (genvar i = 0; i < N; i++) begin : g_row
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (rst)                            q <= '0;
            else if (we && (waddr == AW'(i)))   q <= wdata;
         end
         assign rows[i] = q;
      end
   endgenerate

   assign rdata1 = rows[raddr1];
   assign rdata2 = rows[raddr2];
   assign rdata3 = rows[raddr3];

endmodule

// File: rtl/mcu16_mem.sv
module mcu16_mem #(
   parameter int W      = 16,
   parameter int DEPTH  = 256,
   parameter int IN_AW  = 16,
   localparam int AW    = $clog2(DEPTH)
)(
   input  logic             clk,
   input  logic             we,
   input  logic [IN_AW-1:0] addr,
   input  logic [W-1:0]     wdata,
   output logic [W-1:0]     rdata,
   input  logic [IN_AW-1:0] peek_addr,
   output logic [W-1:0]     peek_data
);

   logic [W-1:0]  words [DEPTH];
   logic [AW-1:0] idx;
   logic [AW-1:0] peek_idx;

   assign idx      = addr[AW-1:0];
   assign peek_idx = peek_addr[AW-1:0];

   generate
      if (AW < IN_AW) begin : g_wrap
         logic unused_hi;
         assign unused_hi = ^{addr[IN_AW-1:AW], peek_addr[IN_AW-1:AW]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we) words[idx] <= wdata;
   end

   assign rdata     = words[idx];
   assign peek_data = words[peek_idx];

endmodule

// File: rtl/mcu16_core.sv
module mcu16_core
   import mcu16_pkg::*;
#(
   parameter int MEM_DEPTH    = 256,
   parameter bit SHARED_ADDER = 1'b1
)(
   input  logic        clk,
   input  logic        rst,
   input  logic        dbg_mem_we,
   input  logic [15:0] dbg_mem_addr,
   input  logic [15:0] dbg_mem_wdata,
   output logic [15:0] dbg_mem_rdata,
   input  logic [3:0]  dbg_rf_sel,
   output logic [15:0] dbg_rf_data,
   output logic [15:0] dbg_pc,
   output logic [3:0]  dbg_state
);

   localparam int NREGS = 1 << REG_AW;

   generate
      if (MEM_DEPTH < 2 || MEM_DEPTH > 65536) begin : g_bad_depth
         $error("mcu16_core: MEM_DEPTH must lie in 2..65536");
      end
      if ((MEM_DEPTH & (MEM_DEPTH - 1)) != 0) begin : g_bad_pow2
         $error("mcu16_core: MEM_DEPTH must be a power of two");
      end
   endgenerate

   state_t              state_q;
   ctrl_t               ctl;
   logic [WORD_W-1:0]   pc_q;
   logic [WORD_W-1:0]   ir_q;
   logic [OP_W-1:0]     f_op;
   logic [REG_AW-1:0]   f_rn;
   logic [REG_AW-1:0]   f_rm;
   logic [WORD_W-1:0]   f_lit;
   logic [WORD_W-1:0]   rd1_data;
   logic [WORD_W-1:0]   rd2_data;
   logic [WORD_W-1:0]   alu_y;
   logic                alu_z;
   logic [WORD_W-1:0]   rf_wdata;
   logic [WORD_W-1:0]   core_addr;
   logic [WORD_W-1:0]   core_wdata;
   logic                core_mem_we;
   logic [WORD_W-1:0]   mem_rdata;
   logic                mem_we;
   logic [WORD_W-1:0]   mem_addr;
   logic [WORD_W-1:0]   mem_wdata;

   assign f_op  = ir_q[15:12];
   assign f_rn  = ir_q[11:8];
   assign f_rm  = ir_q[7:4];
   assign f_lit = {{(WORD_W-LIT_W){1'b0}}, ir_q[LIT_W-1:0]};

   mcu16_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .opcode (f_op),
      .state  (state_q),
      .ctl    (ctl)
   );

   mcu16_regfile #(.W(WORD_W), .N(NREGS)) u_rf (
      .clk    (clk),
      .rst    (rst),
      .we     (ctl.rf_we),
      .waddr  (f_rn),
      .wdata  (rf_wdata),
      .raddr1 (f_rn),
      .rdata1 (rd1_data),
      .raddr2 (f_rm),
      .rdata2 (rd2_data),
      .raddr3 (dbg_rf_sel),
      .rdata3 (dbg_rf_data)
   );

   mcu16_alu #(.W(WORD_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .a  (rd1_data),
      .b  (rd2_data),
      .op (ctl.alu),
      .y  (alu_y),
      .z  (alu_z)
   );

   always_comb begin
      unique case (ctl.wsrc)
         WSRC_MEM: rf_wdata = mem_rdata;
         WSRC_IMM: rf_wdata = f_lit;
         default:  rf_wdata = alu_y;
      endcase
   end

   always_comb begin
      unique case (ctl.asel)
         ASEL_LIT: core_addr = f_lit;
         ASEL_RD1: core_addr = rd1_data;
         default:  core_addr = pc_q;
      endcase
   end

   assign core_wdata  = ctl.wd_rm ? rd2_data : rd1_data;
   assign core_mem_we = ctl.mem_we;

   assign mem_we    = rst ? dbg_mem_we    : core_mem_we;
   assign mem_addr  = rst ? dbg_mem_addr  : core_addr;
   assign mem_wdata = rst ? dbg_mem_wdata : core_wdata;

   mcu16_mem #(.W(WORD_W), .DEPTH(MEM_DEPTH), .IN_AW(WORD_W)) u_mem (
      .clk       (clk),
      .we        (mem_we),
      .addr      (mem_addr),
      .wdata     (mem_wdata),
      .rdata     (mem_rdata),
      .peek_addr (dbg_mem_addr),
      .peek_data (dbg_mem_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst)                        pc_q <= '0;
      else if (ctl.pc_inc)            pc_q <= pc_q + 16'd1;
      else if (ctl.pc_ld_z && alu_z)  pc_q <= f_lit;
   end

   always_ff @(posedge clk) begin
      if (rst)            ir_q <= '0;
      else if (ctl.ir_ld) ir_q <= mem_rdata;
   end

   assign dbg_pc    = pc_q;
   assign dbg_state = state_q;

endmodule

// File: rtl/mcu16_sva.sv
module mcu16_sva
   import mcu16_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic [3:0]  state,
   input logic [15:0] pc,
   input logic [15:0] ir,
   input logic [15:0] rd1,
   input logic        mem_we
);

   // R1
   a_r1_reset_entry: assert property (@(posedge clk)
      rst |=> (state == ST_FETCH && pc == 16'd0));

   // R2
   a_r2_fetch_advances: assert property (@(posedge clk) disable iff (rst)
      (state == ST_FETCH) |=> (state == ST_DECODE && pc == $past(pc) + 16'd1));

   // R2
   a_r2_state_legal: assert property (@(posedge clk) disable iff (rst)
      state <= ST_JZ);

   // R10
   a_r10_undefined_skips: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DECODE && ir[15:12] > 4'd6) |=> (state == ST_FETCH));

   // R11
   a_r11_exec_one_cycle: assert property (@(posedge clk) disable iff (rst)
      (state >= ST_LDD) |=> (state == ST_FETCH));

   // R11
   a_r11_store_states_only: assert property (@(posedge clk) disable iff (rst)
      mem_we |-> (state == ST_STD || state == ST_STI));

   // R9
   a_r9_branch_taken: assert property (@(posedge clk) disable iff (rst)
      (state == ST_JZ && rd1 == 16'd0) |=> (pc == {8'h00, $past(ir[7:0])}));

   // R9
   a_r9_branch_not_taken: assert property (@(posedge clk) disable iff (rst)
      (state == ST_JZ && rd1 != 16'd0) |=> $stable(pc));

endmodule

bind mcu16_core mcu16_sva u_sva (
   .clk    (clk),
   .rst    (rst),
   .state  (state_q),
   .pc     (pc_q),
   .ir     (ir_q),
   .rd1    (rd1_data),
   .mem_we (core_mem_we)
);

// File: tb/sim_mcu16_core.sv
`timescale 1ns/1ps
module sim_mcu16_core;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        dbg_mem_we = 1'b0;
   logic [15:0] dbg_mem_addr = 16'd0;
   logic [15:0] dbg_mem_wdata = 16'd0;
   logic [15:0] dbg_mem_rdata;
   logic [3:0]  dbg_rf_sel = 4'd0;
   logic [15:0] dbg_rf_data;
   logic [15:0] dbg_pc;
   logic [3:0]  dbg_state;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [15:0] m_mem [256];
   logic [15:0] m_rf  [16];
   logic [15:0] m_pc;
   logic [15:0] m_ir;
   int          m_st;

   always #4 clk = ~clk;

   mcu16_core u0 (
      .clk           (clk),
      .rst           (rst),
      .dbg_mem_we    (dbg_mem_we),
      .dbg_mem_addr  (dbg_mem_addr),
      .dbg_mem_wdata (dbg_mem_wdata),
      .dbg_mem_rdata (dbg_mem_rdata),
      .dbg_rf_sel    (dbg_rf_sel),
      .dbg_rf_data   (dbg_rf_data),
      .dbg_pc        (dbg_pc),
      .dbg_state     (dbg_state)
   );

   function automatic logic [15:0] enc(int op, int rn, int lit);
      return {op[3:0], rn[3:0], lit[7:0]};
   endfunction

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_pc = 16'd0; m_ir = 16'd0; m_st = 0;
      for (int i = 0; i < 16; i++) m_rf[i] = 16'd0;
   endtask

   task automatic model_step();
      logic [3:0]  rn, rm;
      logic [7:0]  lit;
      rn  = m_ir[11:8];
      rm  = m_ir[7:4];
      lit = m_ir[7:0];
      if (m_st == 0) begin
         m_ir = m_mem[m_pc[7:0]];
         m_pc = m_pc + 16'd1;
         m_st = 1;
      end else if (m_st == 1) begin
         m_st = (int'(m_ir[15:12]) <= 6) ? int'(m_ir[15:12]) + 2 : 0;
      end else begin
         case (m_st)
            2: m_rf[rn] = m_mem[lit];
            3: m_mem[lit] = m_rf[rn];
            4: m_mem[m_rf[rn][7:0]] = m_rf[rm];
            5: m_rf[rn] = {8'h00, lit};
            6: m_rf[rn] = m_rf[rn] + m_rf[rm];
            7: m_rf[rn] = m_rf[rn] - m_rf[rm];
            8: if (m_rf[rn] == 16'd0) m_pc = {8'h00, lit};
            default: ;
         endcase
         m_st = 0;
      end
   endtask

   task automatic step(int k);
      string tag;
      @(posedge clk);
      if (m_st == 1 && m_ir[15:12] > 4'd6) tag = "R10";
      else if (m_st <= 1)                  tag = "R2";
      else if (m_st == 8)                  tag = "R9";
      else                                 tag = "R11";
      model_step();
      #2;
      dbg_rf_sel = k[3:0];
      #1;
      chk(tag, dbg_pc, m_pc);
      chk(tag, {12'd0, dbg_state}, m_st[15:0]);
      chk("R11", dbg_rf_data, m_rf[k % 16]);
   endtask

   task automatic rf_is(string tag, int idx, logic [15:0] exp);
      dbg_rf_sel = idx[3:0];
      #0.01;
      chk(tag, dbg_rf_data, exp);
   endtask

   task automatic mem_is(string tag, int a, logic [15:0] exp);
      dbg_mem_addr = a[15:0];
      #0.01;
      chk(tag, dbg_mem_rdata, exp);
   endtask

   task automatic check_reset_state();
      chk("R1", dbg_pc, 16'd0);
      chk("R1", {12'd0, dbg_state}, 16'd0);
      for (int i = 0; i < 16; i++) rf_is("R1", i, 16'd0);
   endtask

   initial begin
      logic [15:0] prog [21];
      prog[0]  = enc(3, 1, 8'h05);
      prog[1]  = enc(3, 2, 8'h03);
      prog[2]  = enc(4, 1, 8'h20);
      prog[3]  = enc(5, 2, 8'h10);
      prog[4]  = enc(1, 1, 8'h80);
      prog[5]  = enc(0, 3, 8'h80);
      prog[6]  = enc(3, 4, 8'h90);
      prog[7]  = enc(2, 4, 8'h20);
      prog[8]  = enc(0, 5, 8'h90);
      prog[9]  = enc(3, 6, 8'h00);
      prog[10] = enc(6, 6, 8'h0C);
      prog[11] = enc(3, 7, 8'hAA);
      prog[12] = enc(6, 1, 8'h00);
      prog[13] = 16'h7ABC;
      prog[14] = 16'hFFFF;
      prog[15] = enc(3, 8, 8'hF8);
      prog[16] = enc(4, 8, 8'h80);
      prog[17] = enc(2, 8, 8'h50);
      prog[18] = enc(3, 9, 8'hFF);
      prog[19] = enc(5, 1, 8'h10);
      prog[20] = enc(6, 1, 8'h14);

      // R12: load memory through the debug port while reset is held
      rst = 1'b1;
      for (int a = 0; a < 256; a++) begin
         @(negedge clk);
         dbg_mem_we    = 1'b1;
         dbg_mem_addr  = a[15:0];
         dbg_mem_wdata = (a < 21) ? prog[a] : 16'd0;
         m_mem[a]      = dbg_mem_wdata;
      end
      @(negedge clk);
      dbg_mem_we = 1'b0;
      model_reset();
      check_reset_state();

      rst = 1'b0;
      for (int k = 0; k < 100; k++) begin
         if (k == 60) begin
            dbg_mem_we    = 1'b1;   // R12: must be ignored out of reset
            dbg_mem_addr  = 16'h00F5;
            dbg_mem_wdata = 16'h1234;
         end else begin
            dbg_mem_we = 1'b0;
         end
         step(k);
      end
      dbg_mem_we = 1'b0;

      rf_is("R4", 3, 16'h0008);
      rf_is("R3", 4, 16'h0090);
      rf_is("R6", 5, 16'hFFFB);
      rf_is("R7", 9, 16'h00FF);
      rf_is("R8", 2, 16'hFFFB);
      rf_is("R8", 1, 16'h0000);
      rf_is("R8", 8, 16'h01F0);
      rf_is("R9", 7, 16'h0000);
      mem_is("R5", 16'h0080, 16'h0008);
      mem_is("R6", 16'h0090, 16'hFFFB);
      mem_is("R12", 16'h00F0, 16'hFFFB);
      mem_is("R12", 16'h01F0, 16'hFFFB);
      mem_is("R12", 16'h00F5, 16'h0000);
      for (int a = 0; a < 256; a++) mem_is("R10", a, m_mem[a]);

      // R1: reset again mid-run
      @(negedge clk);
      rst = 1'b1;
      @(posedge clk);
      #3;
      model_reset();
      check_reset_state();
      @(negedge clk);
      rst = 1'b0;

      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule